// File: doc/BRIEF.md
# Bounding-Box Tile Binner

This block sorts screen-space triangles into square screen tiles. For every triangle it receives (three vertices in integer pixel coordinates plus a triangle identifier), it forms the axis-aligned bounding box of the vertices and clips that box to the screen. It then finds every tile of a uniform grid that the clipped box touches. Each touched tile is sent out as a single record on a valid/ready stream, one record per clock when the consumer is ready. A triangle that touches no part of the screen produces nothing.

The block also keeps two running totals: the number of triangles binned and the number of tile records sent. A downstream observer can divide the second by the first to get the average overlap factor of a scene. The tile side is a power of two set by a parameter, which lets the same block serve tilings from 8x8 up to 128x128 pixels on a default 1024x768 screen. A new triangle is taken only when the previous one has been fully emitted.

Top module: `tile_binner`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `out_valid` is 0, `in_ready` is 1 and both `tri_count` and `rec_count` are 0.
- R2: For an accepted on-screen triangle, the emitted tile columns run from floor(xmin/S) to floor(xmax/S) and the rows from floor(ymin/S) to floor(ymax/S), where xmin/xmax/ymin/ymax are taken over the three vertices and S = 2^TILE_LOG2 (8 by default).
- R3: Records for one triangle come out in row-major order: `out_tx` increases by one per record within a row, and after the last column `out_ty` increases by one and `out_tx` restarts at the first column.
- R4: `out_last` is 1 on the final record of a triangle and 0 on every other record, so each binned triangle has exactly one record with the flag set.
- R5: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R6: `in_ready` is 0 from the cycle after a triangle is accepted until its last record is handed over, and it returns to 1 in the cycle after that handshake; `in_valid` raised while `in_ready` is 0 has no effect on the records or the counters.
- R7: Vertex coordinates below 0 are treated as 0, and coordinates beyond the screen are treated as the last pixel column (SCR_W-1) or row (SCR_H-1).
- R8: A triangle whose bounding box lies entirely off screen (xmax < 0, ymax < 0, xmin >= SCR_W or ymin >= SCR_H) is accepted but produces no record, leaves `in_ready` at 1 and is not counted.
- R9: `tri_count` rises by one for each accepted on-screen triangle and `rec_count` rises by one for each record handshake (`out_valid` and `out_ready` both 1); neither changes otherwise.
- R10: Every record of a triangle carries in `out_id` the identifier given with that triangle on `in_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A triangle is offered |
| in_ready | output | 1 | Block can take a triangle this cycle |
| in_id | input | ID_W | Identifier of the offered triangle |
| in_x0 | input | CW | Vertex 0 x, signed pixels |
| in_y0 | input | CW | Vertex 0 y, signed pixels |
| in_x1 | input | CW | Vertex 1 x, signed pixels |
| in_y1 | input | CW | Vertex 1 y, signed pixels |
| in_x2 | input | CW | Vertex 2 x, signed pixels |
| in_y2 | input | CW | Vertex 2 y, signed pixels |
| out_valid | output | 1 | A tile record is presented |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_id | output | ID_W | Identifier of the triangle for this tile |
| out_tx | output | TX_W | Tile column |
| out_ty | output | TY_W | Tile row |
| out_last | output | 1 | Final tile record of the triangle |
| tri_count | output | CNT_W | Number of triangles binned |
| rec_count | output | CNT_W | Number of tile records handed over |

## Verification
A triangle accepted at one rising edge shows its first tile record, its cleared `in_ready` and its incremented `tri_count` after that same edge. Each handshake edge then brings the next record and the next `rec_count`, and the edge that takes the last record brings `in_ready` back. The bench drives inputs and samples outputs on falling edges, so every check looks at the state exactly one edge after the stimulus that caused it. Stall cycles are inserted by dropping `out_ready` for one falling-to-falling interval, and the held record is compared again before the stream resumes.

// File: rtl/tbin_pkg.sv
package tbin_pkg;

  // walker phase: idle and able to accept, or emitting tile records
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_EMIT = 1'b1
  } walk_state_t;

endpackage

// File: rtl/tbin_bbox.sv
// Bounding box of three vertices, clipped to the screen and turned into
// an inclusive range of tile columns and rows.
module tbin_bbox #(
  parameter int CW        = 12,
  parameter int SCR_W     = 1024,
  parameter int SCR_H     = 768,
  parameter int TILE_LOG2 = 3,
  parameter int TX_W      = 7,
  parameter int TY_W      = 7
) (
  input  logic signed [CW-1:0] x0,
  input  logic signed [CW-1:0] y0,
  input  logic signed [CW-1:0] x1,
  input  logic signed [CW-1:0] y1,
  input  logic signed [CW-1:0] x2,
  input  logic signed [CW-1:0] y2,
  output logic                 off_screen,
  output logic [TX_W-1:0]      tx_lo,
  output logic [TX_W-1:0]      tx_hi,
  output logic [TY_W-1:0]      ty_lo,
  output logic [TY_W-1:0]      ty_hi
);

  localparam logic signed [CW-1:0] XLAST = CW'(SCR_W - 1);
  localparam logic signed [CW-1:0] YLAST = CW'(SCR_H - 1);

  logic signed [CW-1:0] xmn, xmx, ymn, ymx;
  logic signed [CW-1:0] xlo_c, xhi_c, ylo_c, yhi_c;

  always_comb begin
    xmn = x0;
    xmx = x0;
    ymn = y0;
    ymx = y0;
    if (x1 < xmn) xmn = x1;
    if (x2 < xmn) xmn = x2;
    if (x1 > xmx) xmx = x1;
    if (x2 > xmx) xmx = x2;
    if (y1 < ymn) ymn = y1;
    if (y2 < ymn) ymn = y2;
    if (y1 > ymx) ymx = y1;
    if (y2 > ymx) ymx = y2;
  end

  always_comb begin
    off_screen = (xmx < 0) || (ymx < 0) || (xmn > XLAST) || (ymn > YLAST);
    xlo_c = (xmn < 0) ? '0 : xmn;
    ylo_c = (ymn < 0) ? '0 : ymn;
    xhi_c = (xmx > XLAST) ? XLAST : xmx;
    yhi_c = (ymx > YLAST) ? YLAST : ymx;
  end

  // tile side is a power of two: the tile index is a right shift
  assign tx_lo = TX_W'(xlo_c >>> TILE_LOG2);
  assign tx_hi = TX_W'(xhi_c >>> TILE_LOG2);
  assign ty_lo = TY_W'(ylo_c >>> TILE_LOG2);
  assign ty_hi = TY_W'(yhi_c >>> TILE_LOG2);

endmodule

// File: rtl/tbin_walk.sv
// Steps through a loaded tile rectangle in row-major order and presents
// one registered record per step on a valid/ready stream.
module tbin_walk
  import tbin_pkg::*;
#(
  parameter int TX_W = 7,
  parameter int TY_W = 7,
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TX_W-1:0] ld_xlo,
  input  logic [TX_W-1:0] ld_xhi,
  input  logic [TY_W-1:0] ld_ylo,
  input  logic [TY_W-1:0] ld_yhi,
  input  logic [ID_W-1:0] ld_id,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [TX_W-1:0] out_tx,
  output logic [TY_W-1:0] out_ty,
  output logic [ID_W-1:0] out_id,
  output logic            out_last,
  output logic            fire
);

  localparam logic [TX_W-1:0] ONE_X = 1;
  localparam logic [TY_W-1:0] ONE_Y = 1;

  walk_state_t     state_q;
  logic [TX_W-1:0] cx_q, xlo_q, xhi_q;
  logic [TY_W-1:0] cy_q, yhi_q;
  logic [ID_W-1:0] id_q;
  logic            last_q;

  assign out_valid = (state_q == WK_EMIT);
  assign fire      = out_valid && out_ready;
  assign out_tx    = cx_q;
  assign out_ty    = cy_q;
  assign out_id    = id_q;
  assign out_last  = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WK_IDLE;
      cx_q    <= '0;
      cy_q    <= '0;
      xlo_q   <= '0;
      xhi_q   <= '0;
      yhi_q   <= '0;
      id_q    <= '0;
      last_q  <= 1'b0;
    end else if (load) begin
      state_q <= WK_EMIT;
      cx_q    <= ld_xlo;
      cy_q    <= ld_ylo;
      xlo_q   <= ld_xlo;
      xhi_q   <= ld_xhi;
      yhi_q   <= ld_yhi;
      id_q    <= ld_id;
      last_q  <= (ld_xlo == ld_xhi) && (ld_ylo == ld_yhi);
    end else if (fire) begin
      if (last_q) begin
        state_q <= WK_IDLE;
        last_q  <= 1'b0;
      end else if (cx_q == xhi_q) begin
        cx_q   <= xlo_q;
        cy_q   <= cy_q + ONE_Y;
        last_q <= ((cy_q + ONE_Y) == yhi_q) && (xlo_q == xhi_q);
      end else begin
        cx_q   <= cx_q + ONE_X;
        last_q <= (cy_q == yhi_q) && ((cx_q + ONE_X) == xhi_q);
      end
    end
  end

endmodule

// File: rtl/tbin_count.sv
// Running total that rises by one on each pulse of its enable.
module tbin_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);

  localparam logic [CNT_W-1:0] STEP = 1;

  always_ff @(posedge clk) begin
    if (rst)      total <= '0;
    else if (inc) total <= total + STEP;
  end

endmodule

// File: rtl/tile_binner.sv
module tile_binner #(
  parameter int CW        = 12,
  parameter int SCR_W     = 1024,
  parameter int SCR_H     = 768,
  parameter int TILE_LOG2 = 3,
  parameter int ID_W      = 16,
  parameter int CNT_W     = 32,
  localparam int TS       = 1 << TILE_LOG2,
  localparam int NTX      = (SCR_W + TS - 1) / TS,
  localparam int NTY      = (SCR_H + TS - 1) / TS,
  localparam int TX_W     = (NTX > 1) ? $clog2(NTX) : 1,
  localparam int TY_W     = (NTY > 1) ? $clog2(NTY) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ID_W-1:0]      in_id,
  input  logic signed [CW-1:0] in_x0,
  input  logic signed [CW-1:0] in_y0,
  input  logic signed [CW-1:0] in_x1,
  input  logic signed [CW-1:0] in_y1,
  input  logic signed [CW-1:0] in_x2,
  input  logic signed [CW-1:0] in_y2,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ID_W-1:0]      out_id,
  output logic [TX_W-1:0]      out_tx,
  output logic [TY_W-1:0]      out_ty,
  output logic                 out_last,
  output logic [CNT_W-1:0]     tri_count,
  output logic [CNT_W-1:0]     rec_count
);

  logic            off_screen;
  logic [TX_W-1:0] bx_lo, bx_hi;
  logic [TY_W-1:0] by_lo, by_hi;
  logic            accept, load, fire;

  tbin_bbox #(
    .CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .TILE_LOG2(TILE_LOG2),
    .TX_W(TX_W), .TY_W(TY_W)
  ) u_bbox (
    .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1), .x2(in_x2), .y2(in_y2),
    .off_screen(off_screen),
    .tx_lo(bx_lo), .tx_hi(bx_hi), .ty_lo(by_lo), .ty_hi(by_hi)
  );

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign load     = accept && !off_screen;

  tbin_walk #(
    .TX_W(TX_W), .TY_W(TY_W), .ID_W(ID_W)
  ) u_walk (
    .clk(clk), .rst(rst), .load(load),
    .ld_xlo(bx_lo), .ld_xhi(bx_hi), .ld_ylo(by_lo), .ld_yhi(by_hi),
    .ld_id(in_id), .out_ready(out_ready),
    .out_valid(out_valid), .out_tx(out_tx), .out_ty(out_ty),
    .out_id(out_id), .out_last(out_last), .fire(fire)
  );

  tbin_count #(.CNT_W(CNT_W)) u_tri_cnt (
    .clk(clk), .rst(rst), .inc(load), .total(tri_count)
  );

  tbin_count #(.CNT_W(CNT_W)) u_rec_cnt (
    .clk(clk), .rst(rst), .inc(fire), .total(rec_count)
  );

endmodule

// File: rtl/tile_binner_chk.sv
module tile_binner_chk #(
  parameter int ID_W  = 16,
  parameter int TX_W  = 7,
  parameter int TY_W  = 7,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ID_W-1:0]  out_id,
  input logic [TX_W-1:0]  out_tx,
  input logic [TY_W-1:0]  out_ty,
  input logic             out_last,
  input logic [CNT_W-1:0] tri_count,
  input logic [CNT_W-1:0] rec_count
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && tri_count == '0 && rec_count == '0));

  // R3
  row_major_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_valid &&
      ((out_tx == $past(out_tx) + 1'b1 && out_ty == $past(out_ty)) ||
       (out_ty == $past(out_ty) + 1'b1))));

  // R4
  last_ends_stream_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tx) &&
      $stable(out_ty) && $stable(out_last)));

  // R10
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_id));

  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R9
  rec_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (rec_count == $past(rec_count) + 1'b1));

  // R9
  tri_count_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(tri_count));

endmodule

bind tile_binner tile_binner_chk #(
  .ID_W(ID_W), .TX_W(TX_W), .TY_W(TY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
  .out_tx(out_tx), .out_ty(out_ty), .out_last(out_last),
  .tri_count(tri_count), .rec_count(rec_count)
);

// File: tb/tile_binner_tb.sv
module tile_binner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // x0 y0 x1 y1 x2 y2 id | col_lo col_hi row_lo row_hi off
  localparam int VT [NV][12] = '{
    '{   0,   0,    5,   3,    7,   7,  1,   0,   0,  0,  0, 0 },
    '{  10,  20,   30,   9,   17,  25,  2,   1,   3,  1,  3, 0 },
    '{ 100,  50,   90,  60,   95,  40,  3,  11,  12,  5,  7, 0 },
    '{  -5,  -5,    3,  12,   20,   2,  4,   0,   2,  0,  1, 0 },
    '{1020, 760, 1100, 700, 1010, 800,  5, 126, 127, 87, 95, 0 },
    '{ -10, -10,   -1, -20,   -5,  -3,  6,   0,   0,  0,  0, 1 },
    '{1024,   5, 1030,  10, 1100,  20,  7,   0,   0,  0,  0, 1 },
    '{   7,   8,    8,  15,    8,   8,  8,   0,   1,  1,  1, 0 },
    '{ 500, 300,  500, 300,  500, 300,  9,  62,  62, 37, 37, 0 },
    '{   0, 767, 1023, 767,  512,   0, 10,   0, 127,  0, 95, 0 }
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [15:0]        in_id = '0;
  logic signed [11:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [15:0]        out_id;
  logic [6:0]         out_tx;
  logic [6:0]         out_ty;
  logic               out_last;
  logic [31:0]        tri_count;
  logic [31:0]        rec_count;

  int checks = 0;
  int fails = 0;
  int exp_tris = 0;
  int exp_recs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_binner u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1),
    .in_y1(in_y1), .in_x2(in_x2), .in_y2(in_y2),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_tx(out_tx), .out_ty(out_ty), .out_last(out_last),
    .tri_count(tri_count), .rec_count(rec_count)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // offer one triangle at a falling edge; returns at the falling edge after acceptance
  task automatic offer(input int x0, input int y0, input int x1, input int y1,
                       input int x2, input int y2, input int id);
    in_x0 = 12'(x0); in_y0 = 12'(y0);
    in_x1 = 12'(x1); in_y1 = 12'(y1);
    in_x2 = 12'(x2); in_y2 = 12'(y2);
    in_id = 16'(id);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // collect the records of a rectangle of tiles, optionally stalling
  task automatic collect(input int cx0, input int cx1, input int cy0, input int cy1,
                         input int id, input bit stall_on);
    for (int ty = cy0; ty <= cy1; ty++) begin
      for (int tx = cx0; tx <= cx1; tx++) begin
        bit lst;
        lst = (tx == cx1) && (ty == cy1);
        chk("R2 out_valid during stream", int'(out_valid), 1);
        chk("R3 tile column", int'(out_tx), tx);
        chk("R3 tile row", int'(out_ty), ty);
        chk("R10 triangle id", int'(out_id), id);
        chk("R4 last flag", int'(out_last), int'(lst));
        chk("R6 in_ready low while emitting", int'(in_ready), 0);
        if (stall_on && ((tx + ty) % 2 == 0)) begin
          out_ready = 1'b0;
          @(negedge clk);
          chk("R5 held valid", int'(out_valid), 1);
          chk("R5 held column", int'(out_tx), tx);
          chk("R5 held row", int'(out_ty), ty);
          chk("R5 held last", int'(out_last), int'(lst));
          out_ready = 1'b1;
        end
        @(negedge clk);
        exp_recs++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 tri_count after reset", int'(tri_count), 0);
    chk("R1 rec_count after reset", int'(rec_count), 0);

    // table of triangles (R2, R3, R4, R7, R8, R9, R10)
    for (int v = 0; v < NV; v++) begin
      offer(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], VT[v][6]);
      if (VT[v][11] != 0) begin
        chk("R8 no record for off-screen", int'(out_valid), 0);
        chk("R8 in_ready stays high", int'(in_ready), 1);
        @(negedge clk);
        chk("R8 still no record", int'(out_valid), 0);
        chk("R8 off-screen not counted", int'(tri_count), exp_tris);
      end else begin
        exp_tris++;
        chk("R9 tri_count after accept", int'(tri_count), exp_tris);
        collect(VT[v][7], VT[v][8], VT[v][9], VT[v][10], VT[v][6], v < 5);
        chk("R6 in_ready back after last", int'(in_ready), 1);
        chk("R4 stream ends after last", int'(out_valid), 0);
        chk("R9 rec_count total", int'(rec_count), exp_recs);
      end
    end

    // R6: a triangle offered while busy is ignored
    offer(16, 16, 23, 23, 20, 31, 77);
    exp_tris++;
    out_ready = 1'b0;
    in_x0 = 12'(200); in_y0 = 12'(200); in_x1 = 12'(300);
    in_y1 = 12'(300); in_x2 = 12'(250); in_y2 = 12'(210);
    in_id = 16'(88);
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    chk("R6 busy offer not counted", int'(tri_count), exp_tris);
    chk("R6 busy offer keeps record id", int'(out_id), 77);
    out_ready = 1'b1;
    collect(2, 2, 2, 3, 77, 1'b0);
    chk("R6 in_ready back", int'(in_ready), 1);
    chk("R9 rec_count after busy offer", int'(rec_count), exp_recs);

    // R1: reset in the middle of a stream
    offer(0, 0, 100, 100, 50, 0, 99);
    out_ready = 1'b0;
    chk("R1 stream started before reset", int'(out_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    out_ready = 1'b1;
    chk("R1 out_valid cleared", int'(out_valid), 0);
    chk("R1 in_ready set", int'(in_ready), 1);
    chk("R1 tri_count cleared", int'(tri_count), 0);
    chk("R1 rec_count cleared", int'(rec_count), 0);

    finish_run();
  end

endmodule